// File: doc/BRIEF.md
# Program Suspend/Resume Controller

This block is the command state machine of a flash device that can pause an array program operation partway through, so that the array can be read, and then carry it on to completion. Commands arrive as one-cycle writes of an 8-bit code and an address. A program command starts a modelled write algorithm. That algorithm is a countdown of `PGM_CYCLES` clock cycles. Its pause points fall wherever the remaining count is a nonzero multiple of `2**CHK_LOG2`.

A suspend request is held until the next pause point. When it takes effect, the device reports itself ready and suspended in the status byte. The remaining count is kept until a resume command restarts the countdown. While suspended, only the four read-mode commands and resume are honoured. The read selector output tells the surrounding datapath what a read returns:
- code 0: array data
- code 1: status byte
- code 2: identifier
- code 3: query table

The command port is a strobe without back-pressure: every cycle with `cmd_valid` high and `ce_n` low delivers exactly one command, and the block never stalls it.

Top module: `pgm_susp_ctrl`

## Requirements
- R1: After reset (`rst_n` low, asynchronous), the status byte is 0x80, `rd_sel` is 0 (array) and no program is running. Status bit 7 means ready, bit 6 means erase suspended, bit 2 means program suspended, and all other bits read 0.
- R2: A command is taken only at a rising edge where `cmd_valid` is 1 and `ce_n` is 0. Code 0x40 taken while idle latches `cmd_addr` into `prog_addr`, sets `rd_sel` to 1 and clears status bit 7. Status bit 7 returns to 1 exactly `PGM_CYCLES` edges after the edge that took the command, provided no suspend intervenes.
- R3: Code 0xB0, at any address and taken while programming, sets `rd_sel` to 1 at that edge. It suspends the program at the first later edge where the remaining count is a nonzero multiple of 8 (default `CHK_LOG2`=3). The count is not decremented at that edge.
- R4: A suspended program shows status bits 7 and 2 both set. If the count runs out before a pause point is reached, the program completes with bit 2 clear, and the pending request is dropped.
- R5: While suspended, codes 0xFF, 0x70, 0x90 and 0x98 set `rd_sel` to 0, 1, 2 and 3 respectively.
- R6: While suspended, every other code except 0xD0 is ignored: `rd_sel`, the status byte and `prog_addr` stay unchanged. This covers 0x40, 0xB0 and the clear-status code 0x50.
- R7: Code 0xD0, at any address and taken while suspended, clears status bits 7 and 2 and sets `rd_sel` to 1 at that edge. The program then finishes exactly as many edges later as the remaining count held at suspension.
- R8: `standby` is 1 exactly when `ce_n` is 1 and no program is running, idle or suspended.
- R9: Asserting reset while suspended abandons the program and restores the R1 state. A later program then runs its full length.
- R10: Status bit 6 follows the `erase_susp` input one edge later. Program suspend behaves the same whatever its value.
- R11: While a program is running, every code other than 0xB0 is ignored, and `rd_sel` stays 1.
- R12: While idle, the four read codes set `rd_sel` as in R5. Codes 0xB0 and 0xD0 leave the status byte at 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable |
| cmd_valid | input | 1 | Command write strobe |
| cmd_addr | input | AW | Command address |
| cmd_code | input | 8 | Command code |
| erase_susp | input | 1 | An erase operation is currently suspended |
| status | output | 8 | Status byte |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 identifier, 3 query table |
| standby | output | 1 | Low-power standby indication |
| prog_addr | output | AW | Address of the current or last program |

## Verification
The main pattern issues the suspend command at every running cycle from the first to the last of a program. This separates requests that line up exactly with a pause point from those that must wait up to seven cycles, and from late requests that expire when the count runs out. For each suspension, resume timing shows whether the remaining count was preserved, and a pass through every command code shows which are honoured and which ignored. Separate patterns gate commands with chip enable, send reads during a running program, alternate the erase-suspend flag, and reset in the middle of a suspension.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_SUSP = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    RS_ARRAY  = 2'd0,
    RS_STATUS = 2'd1,
    RS_IDENT  = 2'd2,
    RS_QUERY  = 2'd3
  } rdsel_e;

  typedef enum logic [3:0] {
    CK_NONE,
    CK_PGM,
    CK_SUSP,
    CK_RESUME,
    CK_RD_ARRAY,
    CK_RD_STAT,
    CK_RD_ID,
    CK_RD_QUERY,
    CK_CLR,
    CK_OTHER
  } cmd_kind_e;

  localparam logic [7:0] OP_PROGRAM = 8'h40;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;
  localparam logic [7:0] OP_RESUME  = 8'hD0;
  localparam logic [7:0] OP_RD_ARR  = 8'hFF;
  localparam logic [7:0] OP_RD_STAT = 8'h70;
  localparam logic [7:0] OP_RD_ID   = 8'h90;
  localparam logic [7:0] OP_RD_QRY  = 8'h98;
  localparam logic [7:0] OP_CLR     = 8'h50;

endpackage

// File: rtl/pss_cmd_decode.sv
module pss_cmd_decode
  import pss_pkg::*;
(
  input  logic       strobe,
  input  logic [7:0] code,
  output cmd_kind_e  kind
);

  always_comb begin
    if (!strobe) begin
      kind = CK_NONE;
    end else begin
      unique case (code)
        OP_PROGRAM: kind = CK_PGM;
        OP_SUSPEND: kind = CK_SUSP;
        OP_RESUME:  kind = CK_RESUME;
        OP_RD_ARR:  kind = CK_RD_ARRAY;
        OP_RD_STAT: kind = CK_RD_STAT;
        OP_RD_ID:   kind = CK_RD_ID;
        OP_RD_QRY:  kind = CK_RD_QUERY;
        OP_CLR:     kind = CK_CLR;
        default:    kind = CK_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/pss_pgm_engine.sv
module pss_pgm_engine
  import pss_pkg::*;
#(
  parameter int PGM_CYCLES = 40,
  parameter int CHK_LOG2   = 3,
  parameter int CW         = $clog2(PGM_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_kind_e     kind,
  output phase_e        phase,
  output logic [CW-1:0] remain,
  output logic          pend
);

  localparam logic [CW-1:0] LOAD = CW'(PGM_CYCLES);

  logic at_chk;

  // pause point: remaining count is a nonzero multiple of the checkpoint spacing
  assign at_chk = (remain[CHK_LOG2-1:0] == '0) && (remain != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      remain <= '0;
      pend   <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (kind == CK_PGM) begin
            phase  <= PH_RUN;
            remain <= LOAD;
            pend   <= 1'b0;
          end
        end
        PH_RUN: begin
          if (pend && at_chk) begin
            phase <= PH_SUSP;
            pend  <= 1'b0;
          end else begin
            remain <= remain - 1'b1;
            if (remain == CW'(1)) begin
              phase <= PH_IDLE;
              pend  <= 1'b0;
            end else if (kind == CK_SUSP) begin
              pend <= 1'b1;
            end
          end
        end
        PH_SUSP: begin
          if (kind == CK_RESUME) phase <= PH_RUN;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pss_read_sel.sv
module pss_read_sel
  import pss_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cmd_kind_e kind,
  input  phase_e    phase,
  output rdsel_e    sel
);

  logic   reads_ok;
  rdsel_e read_tgt;
  logic   is_read;

  assign reads_ok = (phase == PH_IDLE) || (phase == PH_SUSP);

  always_comb begin
    is_read  = 1'b1;
    read_tgt = RS_ARRAY;
    unique case (kind)
      CK_RD_ARRAY: read_tgt = RS_ARRAY;
      CK_RD_STAT:  read_tgt = RS_STATUS;
      CK_RD_ID:    read_tgt = RS_IDENT;
      CK_RD_QUERY: read_tgt = RS_QUERY;
      default:     is_read  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= RS_ARRAY;
    end else if (reads_ok && is_read) begin
      sel <= read_tgt;
    end else if ((phase == PH_IDLE && kind == CK_PGM) ||
                 (phase == PH_RUN  && kind == CK_SUSP) ||
                 (phase == PH_SUSP && kind == CK_RESUME)) begin
      sel <= RS_STATUS;
    end
  end

endmodule

// File: rtl/pgm_susp_ctrl.sv
module pgm_susp_ctrl
  import pss_pkg::*;
#(
  parameter int AW         = 16,
  parameter int PGM_CYCLES = 40,
  parameter int CHK_LOG2   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_code,
  input  logic          erase_susp,
  output logic [7:0]    status,
  output logic [1:0]    rd_sel,
  output logic          standby,
  output logic [AW-1:0] prog_addr
);

  localparam int CW = $clog2(PGM_CYCLES + 1);

  cmd_kind_e     kind_w;
  phase_e        phase_w;
  logic [CW-1:0] remain_w;
  logic          pend_w;
  rdsel_e        sel_w;
  logic          esusp_q;
  logic          take_w;

  assign take_w = cmd_valid && !ce_n;

  pss_cmd_decode u_dec (
    .strobe (take_w),
    .code   (cmd_code),
    .kind   (kind_w)
  );

  pss_pgm_engine #(
    .PGM_CYCLES (PGM_CYCLES),
    .CHK_LOG2   (CHK_LOG2),
    .CW         (CW)
  ) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind   (kind_w),
    .phase  (phase_w),
    .remain (remain_w),
    .pend   (pend_w)
  );

  pss_read_sel u_rsel (
    .clk   (clk),
    .rst_n (rst_n),
    .kind  (kind_w),
    .phase (phase_w),
    .sel   (sel_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esusp_q   <= 1'b0;
      prog_addr <= '0;
    end else begin
      esusp_q <= erase_susp;
      if (phase_w == PH_IDLE && kind_w == CK_PGM) prog_addr <= cmd_addr;
    end
  end

  assign status  = {phase_w != PH_RUN, esusp_q, 3'b000, phase_w == PH_SUSP, 2'b00};
  assign rd_sel  = sel_w;
  assign standby = ce_n && (phase_w != PH_RUN);

endmodule

// File: rtl/pss_checker.sv
module pss_checker
  import pss_pkg::*;
#(
  parameter int CW       = 6,
  parameter int CHK_LOG2 = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input cmd_kind_e     kind,
  input phase_e        phase,
  input logic [CW-1:0] remain,
  input rdsel_e        rd_sel,
  input logic [7:0]    status,
  input logic          standby
);

  a_r1_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> status[7] && !status[2]);

  a_r3_pause_on_checkpoint: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> (remain[CHK_LOG2-1:0] == '0) && (remain == $past(remain)));

  a_r3_suspend_selects_status: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && kind == CK_SUSP) |=> rd_sel == RS_STATUS);

  a_r4_suspended_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> status[7]);

  a_r6_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SUSP && kind inside {CK_PGM, CK_SUSP, CK_CLR, CK_OTHER, CK_NONE})
      |=> $stable(rd_sel) && phase == PH_SUSP && $stable(remain));

  a_r7_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SUSP && kind == CK_RESUME) |=> !status[7] && !status[2] && rd_sel == RS_STATUS);

  a_r8_standby_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> ce_n && status[7]);

  a_r11_run_holds_status_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && $past(phase) == PH_RUN) |-> rd_sel == RS_STATUS);

endmodule

bind pgm_susp_ctrl pss_checker #(
  .CW       (CW),
  .CHK_LOG2 (CHK_LOG2)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_n    (ce_n),
  .kind    (kind_w),
  .phase   (phase_w),
  .remain  (remain_w),
  .rd_sel  (sel_w),
  .status  (status),
  .standby (standby)
);

// File: tb/pgm_susp_ctrl_tb.sv
module pgm_susp_ctrl_tb_top;

  localparam int N   = 40;
  localparam int CHK = 8;
  localparam int AW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_code = '0;
  logic          erase_susp = 1'b0;
  logic [7:0]    status;
  logic [1:0]    rd_sel;
  logic          standby;
  logic [AW-1:0] prog_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pgm_susp_ctrl #(.AW(AW), .PGM_CYCLES(N), .CHK_LOG2(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_code(cmd_code), .erase_susp(erase_susp),
    .status(status), .rd_sel(rd_sel), .standby(standby), .prog_addr(prog_addr)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cmd(input logic [7:0] code, input logic [AW-1:0] addr);
    cmd_code  = code;
    cmd_addr  = addr;
    cmd_valid = 1'b1;
    tick();
    cmd_valid = 1'b0;
  endtask

  // ticks until ready, returns number of edges taken
  task automatic wait_ready(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!status[7] && n < N + 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    tick();
    tick();
    check_eq("R1 status", status, 8'h80);
    check_eq("R1 rd_sel", rd_sel, 0);
    rst_n = 1'b1;
    tick();

    // idle behaviour
    cmd(8'hB0, 16'h0123);
    check_eq("R12 suspend in idle", status, 8'h80);
    cmd(8'hD0, 16'h0456);
    check_eq("R12 resume in idle", status, 8'h80);
    cmd(8'h90, 16'h0);
    check_eq("R12 ident", rd_sel, 2);
    cmd(8'h98, 16'h0);
    check_eq("R12 query", rd_sel, 3);
    cmd(8'hFF, 16'h0);
    check_eq("R12 array", rd_sel, 0);

    // chip enable gating
    ce_n = 1'b1;
    cmd(8'h40, 16'h0777);
    check_eq("R2 gated program", status, 8'h80);
    check_eq("R8 standby idle", standby, 1);
    ce_n = 1'b0;
    tick();
    check_eq("R8 standby ce low", standby, 0);

    // full program with reads ignored
    cmd(8'h40, 16'h0007);
    check_eq("R2 busy", status[7], 0);
    check_eq("R2 rd_sel", rd_sel, 1);
    check_eq("R2 prog_addr", prog_addr, 16'h0007);
    cmd(8'hFF, 16'h0);
    check_eq("R11 read during run", rd_sel, 1);
    ce_n = 1'b1;
    tick();
    check_eq("R8 no standby while running", standby, 0);
    ce_n = 1'b0;
    wait_ready(n);
    check_eq("R2 program length", n + 2, N);
    check_eq("R2 done status", status, 8'h80);

    // suspend offset sweep
    for (int d = 1; d < N; d++) begin
      logic [AW-1:0] pa;
      int e;
      int m;
      pa = AW'(d * 37 + 5);
      erase_susp = d[0];
      cmd(8'h40, pa);
      repeat (d - 1) tick();
      cmd(8'hB0, ~pa);
      check_eq("R3 status select", rd_sel, 1);
      wait_ready(e);
      e += d;
      if (N - d >= CHK) begin
        m = ((N - d) / CHK) * CHK;
        check_eq("R3 suspend edge", e, N - m + 1);
        check_eq("R4 suspended bits", {status[7], status[2]}, 2'b11);
        check_eq("R10 erase flag", status[6], int'(d[0]));
        cmd(8'h40, ~pa);
        check_eq("R6 program ignored sel", rd_sel, 1);
        check_eq("R6 program ignored addr", prog_addr, pa);
        cmd(8'hFF, 16'h1);
        check_eq("R5 array", rd_sel, 0);
        cmd(8'h50, 16'h2);
        check_eq("R6 clear ignored", rd_sel, 0);
        cmd(8'hB0, 16'h3);
        check_eq("R6 suspend ignored", {status[7], status[2], rd_sel}, 4'b1100);
        cmd(8'h90, 16'h4);
        check_eq("R5 ident", rd_sel, 2);
        cmd(8'h98, 16'h5);
        check_eq("R5 query", rd_sel, 3);
        cmd(8'h70, 16'h6);
        check_eq("R5 status", rd_sel, 1);
        ce_n = 1'b1;
        tick();
        check_eq("R8 standby suspended", standby, 1);
        cmd(8'hD0, pa);
        check_eq("R2 resume gated", status[2], 1);
        ce_n = 1'b0;
        tick();
        check_eq("R8 standby off", standby, 0);
        cmd(8'hD0, pa ^ 16'h5A5A);
        check_eq("R7 resume clears", {status[7], status[2]}, 2'b00);
        check_eq("R7 resume sel", rd_sel, 1);
        wait_ready(e);
        check_eq("R7 remaining preserved", e, m);
        check_eq("R7 finished unsuspended", status[2], 0);
      end else begin
        check_eq("R4 late request completes", e, N);
        check_eq("R4 no suspend bit", status[2], 0);
      end
      check_eq("R6 prog_addr kept", prog_addr, pa);
    end

    // reset during suspend
    erase_susp = 1'b0;
    cmd(8'h40, 16'h00AA);
    cmd(8'hB0, 16'h0);
    wait_ready(n);
    check_eq("R3 suspend edge", n + 1, 9);
    check_eq("R4 suspended", status[2], 1);
    rst_n = 1'b0;
    tick();
    check_eq("R9 reset status", status, 8'h80);
    check_eq("R9 reset sel", rd_sel, 0);
    rst_n = 1'b1;
    tick();
    cmd(8'h40, 16'h00BB);
    wait_ready(n);
    check_eq("R9 fresh full length", n, N);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule